// File: doc/BRIEF.md
# Console Receiver Register Interface

This block is the processor-facing half of a character console receiver. A separate deserializer hands it one character at a time through a single-cycle strobe, together with a flag that marks a line break instead of a normal character. The block holds the last character in a receive buffer and keeps a status word with a "character waiting" flag and an interrupt-enable flag. It also drives a level interrupt request towards the interrupt controller.

Software reaches the two registers through a simple synchronous register port. The port has a select, a write flag, a byte address and per-byte write enables. Address bit 1 picks the register. Reads return data combinationally in the cycle of the access. Every state change happens at the next rising clock edge. Reading the receive buffer acknowledges the character: the waiting flag drops and the interrupt request is withdrawn.

Top module: `con_rx_regs`

## Requirements
- R1: Byte address bit 1 selects the register: 0 selects the status word and 1 selects the receive buffer. The other address bits are ignored.
- R2: A status read returns the waiting flag in bit 7 and the enable flag in bit 6. All other bits read as 0. When the port is not selected, the read data is 0.
- R3: Only bit 6 (enable) of the status word is writable. A status write without the low-byte enable (`bus_be[0]` = 0) changes nothing. Bit 7 can never be written.
- R4: A status write with bit 6 = 0 clears the enable flag and withdraws the interrupt request at the next edge.
- R5: A status write with bit 6 = 1 while a character is waiting raises the interrupt request at the next edge.
- R6: A buffer read returns the stored character in bits 7:0, with the upper bits 0. At the next edge it clears the waiting flag and the interrupt request.
- R7: Writes to the buffer address leave the buffer, both flags and the interrupt request unchanged.
- R8: A receive strobe stores the character, sets the waiting flag, and raises the interrupt request if enable is 1.
- R9: A character that arrives while one is still waiting overwrites the buffer. No error or overrun bit is set.
- R10: A receive strobe with the break flag set loads the buffer with 0.
- R11: An active-low reset clears the buffer, both flags and the interrupt request.
- R12: When a receive strobe and a buffer read fall in the same cycle, the read returns the old character and the new arrival wins. Afterwards the waiting flag is 1 and the request follows enable.
- R13: The interrupt request is a level. It stays high until a buffer read or an enable = 0 write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (3) | Byte address; bit 1 selects the register |
| bus_be | input | BUS_W/8 (2) | Byte write enables |
| bus_wdata | input | BUS_W (16) | Write data |
| bus_rdata | output | BUS_W (16) | Read data, valid in the cycle of the access |
| rx_strobe | input | 1 | One-cycle pulse: a character has arrived |
| rx_break | input | 1 | The arriving item is a break condition |
| rx_char | input | CHAR_W (8) | Arriving character |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach from the ports is a receive strobe in the same cycle as a buffer read. Both the read's clearing action and the arrival's setting action act on the waiting flag at one edge. The bench first stores a character with enable on. It then drives the buffer read and a second strobe together in one cycle, checks that the old character comes back, and checks that the new one and the interrupt survive. Two further cases only show over several cycles: an overwrite that leaves no error trace, and a status write that lacks the low-byte enable. The bench covers them with status and buffer reads placed right after the stimulus.

// File: rtl/con_rx_pkg.sv
package con_rx_pkg;

   // Register picked by the select address bit.
   typedef enum logic {
      REG_STATUS = 1'b0,
      REG_DATA   = 1'b1
   } reg_sel_e;

   // Decoded access for one cycle.
   typedef struct packed {
      logic rd_status;
      logic rd_data;
      logic wr_status;
   } acc_s;

endpackage

// File: rtl/con_rx_decode.sv
module con_rx_decode
   import con_rx_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int BE_W    = 2,
   parameter int SEL_BIT = 1,
   parameter int IE_BIT  = 6
) (
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BE_W-1:0]   be,
   output acc_s              acc
);

   localparam int IE_LANE = IE_BIT / 8;

   if (SEL_BIT >= ADDR_W) begin : g_bad_sel
      $error("con_rx_decode: SEL_BIT outside the address");
   end
   if (IE_LANE >= BE_W) begin : g_bad_lane
      $error("con_rx_decode: enable bit outside the byte lanes");
   end

   reg_sel_e          which;
   logic [BE_W-1:0]   lane_wr;
   logic              unused_addr;

   assign which       = reg_sel_e'(addr[SEL_BIT]);
   assign unused_addr = ^addr;

   for (genvar g = 0; g < BE_W; g++) begin : g_lane
      assign lane_wr[g] = sel & wr & be[g] & (which == REG_STATUS);
   end

   // Only the lane that holds the enable bit carries a status write.
   assign acc.wr_status = lane_wr[IE_LANE];
   assign acc.rd_status = sel & ~wr & (which == REG_STATUS);
   assign acc.rd_data   = sel & ~wr & (which == REG_DATA);

endmodule

// File: rtl/con_rx_flags.sv
module con_rx_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_status,
   input  logic wr_ie,
   input  logic rd_data,
   input  logic rx_take,
   output logic done,
   output logic ie,
   output logic irq
);

   logic ie_n;
   logic done_n;
   logic irq_n;

   always_comb begin
      ie_n   = wr_status ? wr_ie : ie;
      // An arrival beats the clearing action of a same-cycle buffer read.
      done_n = rx_take | (done & ~rd_data);
      irq_n  = irq;
      if (wr_status && !wr_ie)
         irq_n = 1'b0;
      else if (rx_take)
         irq_n = ie_n | irq;
      else if (wr_status && wr_ie && done && !ie)
         irq_n = 1'b1;
      else if (rd_data)
         irq_n = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
         ie   <= 1'b0;
         irq  <= 1'b0;
      end else begin
         done <= done_n;
         ie   <= ie_n;
         irq  <= irq_n;
      end
   end

endmodule

// File: rtl/con_rx_buffer.sv
module con_rx_buffer #(
   parameter int CHAR_W = 8,
   parameter int BUS_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_take,
   input  logic              rx_break,
   input  logic [CHAR_W-1:0] rx_char,
   output logic [CHAR_W-1:0] char_q,
   output logic [BUS_W-1:0]  word
);

   if (CHAR_W > BUS_W) begin : g_bad_w
      $error("con_rx_buffer: character wider than the bus");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         char_q <= '0;
      else if (rx_take)
         char_q <= rx_break ? '0 : rx_char;
   end

   if (CHAR_W == BUS_W) begin : g_full
      assign word = char_q;
   end else begin : g_ext
      assign word = {{(BUS_W-CHAR_W){1'b0}}, char_q};
   end

endmodule

// File: rtl/con_rx_regs.sv
module con_rx_regs
   import con_rx_pkg::*;
#(
   parameter int BUS_W    = 16,
   parameter int CHAR_W   = 8,
   parameter int ADDR_W   = 3,
   parameter int SEL_BIT  = 1,
   parameter int DONE_BIT = 7,
   parameter int IE_BIT   = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [BUS_W/8-1:0]   bus_be,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   input  logic                 rx_strobe,
   input  logic                 rx_break,
   input  logic [CHAR_W-1:0]    rx_char,
   output logic                 irq
);

   localparam int BE_W = BUS_W / 8;

   if (BUS_W % 8 != 0) begin : g_bad_bus
      $error("con_rx_regs: bus width must be whole bytes");
   end
   if (DONE_BIT == IE_BIT || DONE_BIT >= BUS_W || IE_BIT >= BUS_W) begin : g_bad_bits
      $error("con_rx_regs: bad status bit positions");
   end

   acc_s              acc;
   logic              rd_status;
   logic              rd_data;
   logic              wr_status;
   logic              done_q;
   logic              ie_q;
   logic [CHAR_W-1:0] char_q;
   logic [BUS_W-1:0]  data_word;
   logic [BUS_W-1:0]  status_word;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata;

   con_rx_decode #(
      .ADDR_W (ADDR_W),
      .BE_W   (BE_W),
      .SEL_BIT(SEL_BIT),
      .IE_BIT (IE_BIT)
   ) u_decode (
      .sel (bus_sel),
      .wr  (bus_wr),
      .addr(bus_addr),
      .be  (bus_be),
      .acc (acc)
   );

   assign rd_status = acc.rd_status;
   assign rd_data   = acc.rd_data;
   assign wr_status = acc.wr_status;

   con_rx_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_status(wr_status),
      .wr_ie    (bus_wdata[IE_BIT]),
      .rd_data  (rd_data),
      .rx_take  (rx_strobe),
      .done     (done_q),
      .ie       (ie_q),
      .irq      (irq)
   );

   con_rx_buffer #(
      .CHAR_W(CHAR_W),
      .BUS_W (BUS_W)
   ) u_buffer (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_take (rx_strobe),
      .rx_break(rx_break),
      .rx_char (rx_char),
      .char_q  (char_q),
      .word    (data_word)
   );

   always_comb begin
      status_word           = '0;
      status_word[DONE_BIT] = done_q;
      status_word[IE_BIT]   = ie_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_status)
         bus_rdata = status_word;
      else if (rd_data)
         bus_rdata = data_word;
   end

endmodule

// File: rtl/con_rx_regs_chk.sv
module con_rx_regs_chk #(
   parameter int BUS_W    = 16,
   parameter int CHAR_W   = 8,
   parameter int DONE_BIT = 7,
   parameter int IE_BIT   = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_status,
   input logic              rd_data,
   input logic              wr_status,
   input logic              wr_ie,
   input logic              rx_strobe,
   input logic              rx_break,
   input logic              done,
   input logic              ie,
   input logic              irq,
   input logic [BUS_W-1:0]  rdata,
   input logic [CHAR_W-1:0] char_q
);

   logic [BUS_W-1:0] flag_mask;
   always_comb begin
      flag_mask           = '0;
      flag_mask[DONE_BIT] = 1'b1;
      flag_mask[IE_BIT]   = 1'b1;
   end

   // R2: bits other than the two flags always read 0.
   p_status_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_status |-> ((rdata & ~flag_mask) == '0));

   // R13: the request level tracks a waiting character with enable on.
   p_irq_level_r13: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (done && ie));

   // R4
   p_ie_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && !wr_ie) |=> !irq);

   // R6
   p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_strobe) |=> (!done && !irq));

   // R8
   p_arrival_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> done);

   // R10
   p_break_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_strobe && rx_break) |=> (char_q == '0));

   // R3
   p_ie_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_status |=> $stable(ie));

endmodule

bind con_rx_regs con_rx_regs_chk #(
   .BUS_W   (BUS_W),
   .CHAR_W  (CHAR_W),
   .DONE_BIT(DONE_BIT),
   .IE_BIT  (IE_BIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_status(rd_status),
   .rd_data  (rd_data),
   .wr_status(wr_status),
   .wr_ie    (bus_wdata[IE_BIT]),
   .rx_strobe(rx_strobe),
   .rx_break (rx_break),
   .done     (done_q),
   .ie       (ie_q),
   .irq      (irq),
   .rdata    (bus_rdata),
   .char_q   (char_q)
);

// File: tb/con_rx_regs_bench.sv
module con_rx_regs_bench;

   localparam int CLK_HALF = 10;   // 50 MHz

   typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_RX = 2'd3} op_e;

   typedef struct packed {
      logic [1:0]  op;
      logic        dsel;
      logic [1:0]  be;
      logic [15:0] wd;
      logic [7:0]  ch;
      logic        brk;
      logic [15:0] exp_rd;
      logic        exp_irq;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 27;
   localparam vec_t VEC [NV] = '{
      '{OP_RD,   1'b0, 2'b11, 16'h0000, 8'h00, 1'b0, 16'h0000, 1'b0, 4'd2},  // R2 idle status
      '{OP_RX,   1'b0, 2'b00, 16'h0000, 8'h41, 1'b0, 16'h0000, 1'b0, 4'd8},  // R8 enable off
      '{OP_RD,   1'b0, 2'b11, 16'h0000, 8'h00, 1'b0, 16'h0080, 1'b0, 4'd8},
      '{OP_WR,   1'b0, 2'b11, 16'h0040, 8'h00, 1'b0, 16'h0000, 1'b1, 4'd5},  // R5
      '{OP_RD,   1'b0, 2'b11, 16'h0000, 8'h00, 1'b0, 16'h00C0, 1'b1, 4'd2},
      '{OP_RD,   1'b1, 2'b11, 16'h0000, 8'h00, 1'b0, 16'h0041, 1'b0, 4'd6},  // R6
      '{OP_RD,   1'b0, 2'b11, 16'h0000, 8'h00, 1'b0, 16'h0040, 1'b0, 4'd6},
      '{OP_RX,   1'b0, 2'b00, 16'h0000, 8'h5A, 1'b0, 16'h0000, 1'b1, 4'd8},  // R8 enable on
      '{OP_WR,   1'b0, 2'b11, 16'h0000, 8'h00, 1'b0, 16'h0000, 1'b0, 4'd4},  // R4
      '{OP_RD,   1'b0, 2'b11, 16'h0000, 8'h00, 1'b0, 16'h0080, 1'b0, 4'd4},
      '{OP_WR,   1'b0, 2'b10, 16'hFFFF, 8'h00, 1'b0, 16'h0000, 1'b0, 4'd3},  // R3 high byte only
      '{OP_RD,   1'b0, 2'b11, 16'h0000, 8'h00, 1'b0, 16'h0080, 1'b0, 4'd3},
      '{OP_WR,   1'b0, 2'b01, 16'hFF3F, 8'h00, 1'b0, 16'h0000, 1'b0, 4'd3},  // R3 done not writable
      '{OP_RD,   1'b0, 2'b11, 16'h0000, 8'h00, 1'b0, 16'h0080, 1'b0, 4'd3},
      '{OP_WR,   1'b0, 2'b01, 16'hFFFF, 8'h00, 1'b0, 16'h0000, 1'b1, 4'd5},
      '{OP_RD,   1'b0, 2'b11, 16'h0000, 8'h00, 1'b0, 16'h00C0, 1'b1, 4'd2},
      '{OP_WR,   1'b1, 2'b11, 16'h00AA, 8'h00, 1'b0, 16'h0000, 1'b1, 4'd7},  // R7
      '{OP_RD,   1'b1, 2'b11, 16'h0000, 8'h00, 1'b0, 16'h005A, 1'b0, 4'd7},
      '{OP_RX,   1'b0, 2'b00, 16'h0000, 8'h11, 1'b0, 16'h0000, 1'b1, 4'd9},  // R9
      '{OP_RX,   1'b0, 2'b00, 16'h0000, 8'h22, 1'b0, 16'h0000, 1'b1, 4'd9},
      '{OP_RD,   1'b0, 2'b11, 16'h0000, 8'h00, 1'b0, 16'h00C0, 1'b1, 4'd9},
      '{OP_RD,   1'b1, 2'b11, 16'h0000, 8'h00, 1'b0, 16'h0022, 1'b0, 4'd9},
      '{OP_RX,   1'b0, 2'b00, 16'h0000, 8'h7E, 1'b1, 16'h0000, 1'b1, 4'd10}, // R10
      '{OP_IDLE, 1'b0, 2'b00, 16'h0000, 8'h00, 1'b0, 16'h0000, 1'b1, 4'd13}, // R13
      '{OP_RD,   1'b1, 2'b11, 16'h0000, 8'h00, 1'b0, 16'h0000, 1'b0, 4'd10},
      '{OP_WR,   1'b0, 2'b01, 16'h0000, 8'h00, 1'b0, 16'h0000, 1'b0, 4'd4},
      '{OP_RD,   1'b0, 2'b11, 16'h0000, 8'h00, 1'b0, 16'h0000, 1'b0, 4'd2}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [1:0]  bus_be = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        rx_strobe = 1'b0;
   logic        rx_break = 1'b0;
   logic [7:0]  rx_char = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [15:0] got_rd;

   always #CLK_HALF clk = ~clk;

   con_rx_regs u_con_rx_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .rx_strobe(rx_strobe), .rx_break(rx_break),
      .rx_char(rx_char), .irq(irq)
   );

   task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One cycle: drive at the falling edge, sample read data before the
   // rising edge, sample the registered request just after it.
   task automatic step(input logic [1:0] op, input logic dsel, input logic hi_addr,
                       input logic [1:0] be, input logic [15:0] wd,
                       input logic rx, input logic [7:0] ch, input logic brk);
      @(negedge clk);
      bus_sel   = (op == OP_RD) || (op == OP_WR);
      bus_wr    = (op == OP_WR);
      bus_addr  = {hi_addr, dsel, 1'b0};
      bus_be    = be;
      bus_wdata = wd;
      rx_strobe = rx;
      rx_char   = ch;
      rx_break  = brk;
      #2 got_rd = bus_rdata;
      @(posedge clk);
      #1;
      bus_sel = 1'b0; bus_wr = 1'b0; rx_strobe = 1'b0; rx_break = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check16("R11 irq in reset", {15'd0, irq}, 16'h0000);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         vec_t v = VEC[i];
         step(v.op, v.dsel, i[0], v.be, v.wd, v.op == OP_RX, v.ch, v.brk);
         if (v.op == OP_RD)
            check16($sformatf("R%0d/R1 read step %0d", v.req, i), got_rd, v.exp_rd);
         check16($sformatf("R%0d irq step %0d", v.req, i), {15'd0, irq}, {15'd0, v.exp_irq});
      end

      // R12: arrival in the same cycle as a buffer read
      step(OP_WR, 1'b0, 1'b0, 2'b01, 16'h0040, 1'b0, 8'h00, 1'b0);
      step(OP_IDLE, 1'b0, 1'b0, 2'b00, 16'h0000, 1'b1, 8'h33, 1'b0);
      step(OP_RD, 1'b1, 1'b0, 2'b11, 16'h0000, 1'b1, 8'h44, 1'b0);
      check16("R12 old char returned", got_rd, 16'h0033);
      check16("R12 irq kept", {15'd0, irq}, 16'h0001);
      step(OP_RD, 1'b0, 1'b0, 2'b11, 16'h0000, 1'b0, 8'h00, 1'b0);
      check16("R12 status after", got_rd, 16'h00C0);
      step(OP_RD, 1'b1, 1'b1, 2'b11, 16'h0000, 1'b0, 8'h00, 1'b0);
      check16("R12 new char", got_rd, 16'h0044);

      // R11: reset with a character waiting and enable on
      step(OP_IDLE, 1'b0, 1'b0, 2'b00, 16'h0000, 1'b1, 8'h99, 1'b0);
      check16("R11 irq before reset", {15'd0, irq}, 16'h0001);
      @(negedge clk);
      rst_n = 1'b0;
      #2 check16("R11 irq cleared", {15'd0, irq}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      step(OP_RD, 1'b0, 1'b0, 2'b11, 16'h0000, 1'b0, 8'h00, 1'b0);
      check16("R11 status cleared", got_rd, 16'h0000);
      step(OP_RD, 1'b1, 1'b0, 2'b11, 16'h0000, 1'b0, 8'h00, 1'b0);
      check16("R11 buffer cleared", got_rd, 16'h0000);
      check16("R2 idle bus reads 0", bus_rdata, 16'h0000);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule